// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the receive half of a descriptor-driven DMA engine that sits behind an Ethernet MAC. Software builds a circular ring of descriptors in memory. Each descriptor spans 32 bytes. It holds a control and status word, a word with two buffer sizes, and a start address for each of the two buffers. The engine walks that ring. It first checks that the current descriptor belongs to hardware. It then reads the buffer sizes and addresses and waits for the start of a frame. The frame's bytes go into buffer 1 and then buffer 2. At the end of the frame the engine writes one status word back to the descriptor. That write carries the length, the segment flags and the error flags, and it clears the ownership flag so that software gets the descriptor back. The engine then moves on to the next descriptor.

When the engine finds a descriptor that software still owns, it suspends. A poll-demand strobe from software makes it read that same descriptor again. The ring has no length register. A flag in the descriptor's size word marks the last entry, and the engine then returns to the ring base. Bytes that do not fit in the two buffers are dropped and reported as an overflow. Clearing the run bit lets any frame in progress complete. The engine then stops and keeps its ring pointer, and setting the bit again resumes at that pointer.

The engine is built around one state machine with these states: IDLE, RD_OWN, SUSPEND, RD_SIZE, RD_BUF1, RD_BUF2, WAIT_SOF, RECV, WR_DATA, DISCARD and WR_STAT.

- **Start:** IDLE goes to RD_OWN when run is high.
- **Ownership check:** RD_OWN goes to RD_SIZE if the ownership bit is set, and to SUSPEND if it is clear.
- **Suspend:** SUSPEND goes back to RD_OWN on a poll strobe, and to IDLE when run is low.
- **Descriptor fetch:** RD_SIZE, RD_BUF1 and RD_BUF2 follow one another, each on a memory acknowledge.
- **Waiting for a frame:** RD_BUF2 leads to WAIT_SOF. WAIT_SOF goes to RECV or WR_DATA on the first byte of a frame, and to IDLE if run drops before a frame starts.
- **Receiving:** RECV goes to WR_DATA each time a memory word is complete. RECV or WAIT_SOF goes to DISCARD when the capacity is exceeded.
- **Ending a frame:** WR_DATA goes back to RECV, or to WR_STAT at the end of the frame. DISCARD goes to WR_STAT on the end-of-frame byte.
- **Writeback:** WR_STAT goes to RD_OWN when run is high, or to IDLE when it is low.

Top module: `rx_desc_wb_engine`

## Requirements
- R1: After reset, mem_req and rx_ready are low, and no memory access takes place while run is low.
- R2: The engine reads descriptor word 0 at the ring pointer. If bit 31 (ownership) is set, it reads the size word, the buffer 1 address and the buffer 2 address at pointer offsets 4, 8 and 12. If bit 31 is clear, it suspends: rx_ready stays low and no further reads are made.
- R3: A poll strobe during suspend makes the engine read word 0 again at the same pointer.
- R4: Capacity is the size-word field at bits 12:0 (buffer 1) plus the field at bits 28:16 (buffer 2). Frame bytes fill buffer 1 in order from its start address, then buffer 2. A byte bound for address a is written to byte lane a[1:0] (bits 8*a[1:0]+7 down to 8*a[1:0]) of the word at a with its low two bits cleared.
- R5: Bytes beyond the capacity are not written. For such a frame, bit 11 (overflow) is set and the stored length equals the capacity.
- R6: The writeback word 0 has bit 31 clear, the length in bits 29:16, and bits 9 (first segment) and 8 (last segment) set. Bit 5 copies rx_ftype as sampled on the start byte. When bit 5 is set, the reported length is the stored length minus 4, with a floor of 0.
- R7: Bit 1 is rx_crc_err as sampled on the end-of-frame byte. Bit 3 is set if rx_phy_err was high on any byte of the frame. Bits 4, 7, 12 and 14 are 0. Bit 15 is the OR of bits 1, 3, 4, 7, 11, 12 and 14.
- R8: After a writeback, the pointer advances by 32 bytes, unless bit 15 of that descriptor's size word is set. In that case it returns to the ring base.
- R9: While the engine waits for a frame, bytes without rx_sof are accepted and dropped. Nothing is stored from them.
- R10: When run goes low during a frame, the frame is completed and written back, and then no further memory accesses occur. When run is set again, the engine resumes at the held pointer. ring_base is taken only at the first start after reset.
- R11: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Start bit; low halts at a frame boundary |
| poll | input | 1 | Poll-demand strobe, one cycle |
| ring_base | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_ftype | input | 1 | Frame-type flag, sampled on the start byte |
| rx_crc_err | input | 1 | CRC error, sampled on the end byte |
| rx_phy_err | input | 1 | Receive error on this byte |

## Verification
The four descriptor reads complete within eight cycles of a start or poll, because each read waits one cycle for its acknowledge. The bench therefore checks the read count and the last read address after a 15-cycle window. rx_ready falls in the cycle after a byte that completes a word, a buffer or the frame, and the byte-lane write lands two cycles later. The status writeback follows the final data write by two more cycles. For this reason the bench does not sample memory at a fixed edge. Instead it polls the descriptor's ownership bit under a bound and only then compares the status word and every buffer byte, including one guard byte past each buffer, against values computed from the sizes and the frame length.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_OWN, ST_SUSPEND, ST_RD_SIZE, ST_RD_BUF1, ST_RD_BUF2,
        ST_WAIT_SOF, ST_RECV, ST_WR_DATA, ST_DISCARD, ST_WR_STAT
    } rxd_state_e;

    localparam int LEN_W       = 14;
    localparam int SZ_W        = 13;
    localparam int DESC_STRIDE = 32;
    localparam int OWN_BIT     = 31;
    localparam int LEN_LSB     = 16;
    localparam int FIRST_BIT   = 9;
    localparam int LAST_BIT    = 8;
    localparam int FTYPE_BIT   = 5;
    localparam int CRC_BIT     = 1;
    localparam int PHY_BIT     = 3;
    localparam int WDOG_BIT    = 4;
    localparam int GIANT_BIT   = 7;
    localparam int OVF_BIT     = 11;
    localparam int LENERR_BIT  = 12;
    localparam int DESCERR_BIT = 14;
    localparam int SUM_BIT     = 15;
    localparam int EOR_BIT     = 15;
    localparam int SZ1_LSB     = 0;
    localparam int SZ2_LSB     = 16;
endpackage

// File: rtl/rxd_buf_map.sv
module rxd_buf_map
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [SZ_W-1:0]  size1,
    input  logic [SZ_W-1:0]  size2,
    input  logic [AW-1:0]    buf1,
    input  logic [AW-1:0]    buf2,
    input  logic [LEN_W-1:0] pos,
    output logic [AW-1:0]    byte_addr,
    output logic [LEN_W-1:0] cap,
    output logic             end_b1,
    output logic             end_cap,
    output logic             full
);
    logic [LEN_W-1:0] sz1_ext;
    logic [LEN_W-1:0] pos_nxt;
    logic             in_b1;

    always_comb begin
        sz1_ext   = LEN_W'(size1);
        cap       = sz1_ext + LEN_W'(size2);
        pos_nxt   = pos + LEN_W'(1);
        in_b1     = pos < sz1_ext;
        byte_addr = in_b1 ? (buf1 + AW'(pos)) : (buf2 + AW'(pos - sz1_ext));
        end_b1    = (pos_nxt == sz1_ext);
        end_cap   = (pos_nxt == cap);
        full      = (pos >= cap);
    end
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
    import rxd_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  logic             ftype,
    input  logic             crc,
    input  logic             phy,
    input  logic             ovf,
    output logic [31:0]      word
);
    logic [LEN_W-1:0] len_rep;

    always_comb begin
        if (ftype)
            len_rep = (len >= LEN_W'(4)) ? (len - LEN_W'(4)) : '0;
        else
            len_rep = len;
        word                    = '0;
        word[LEN_LSB +: LEN_W]  = len_rep;
        word[FIRST_BIT]         = 1'b1;
        word[LAST_BIT]          = 1'b1;
        word[FTYPE_BIT]         = ftype;
        word[CRC_BIT]           = crc;
        word[PHY_BIT]           = phy;
        word[OVF_BIT]           = ovf;
        word[SUM_BIT]           = word[CRC_BIT] | word[PHY_BIT] | word[WDOG_BIT] |
                                  word[GIANT_BIT] | word[OVF_BIT] | word[LENERR_BIT] |
                                  word[DESCERR_BIT];
    end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr,
    output logic          valid
);
    localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            valid <= 1'b0;
        end else if (load) begin
            ptr   <= base;
            valid <= 1'b1;
        end else if (advance) begin
            ptr   <= wrap ? base : (ptr + STEP);
        end
    end

    p_wrap_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && wrap) |=> (ptr == $past(base)));

    p_step_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !wrap) |=> (ptr == $past(ptr) + STEP));
endmodule

// File: rtl/rx_desc_wb_engine.sv
module rx_desc_wb_engine
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          poll,
    input  logic [AW-1:0] ring_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_ftype,
    input  logic          rx_crc_err,
    input  logic          rx_phy_err
);
    rxd_state_e state, nxt;

    logic [AW-1:0]    ptr;
    logic             ptr_valid;
    logic [SZ_W-1:0]  size1, size2;
    logic             eor;
    logic [AW-1:0]    b1, b2;
    logic [LEN_W-1:0] pos;
    logic [31:0]      wbuf;
    logic [3:0]       wbe;
    logic [AW-1:0]    waddr;
    logic             done, ovf, ftype, crc, phy;

    logic [AW-1:0]    byte_addr;
    logic [LEN_W-1:0] cap;
    logic             end_b1, end_cap, full;
    logic [31:0]      stat_word;
    logic [1:0]       lane;
    logic             take, flush_now, ptr_load, ptr_adv;

    rxd_buf_map #(.AW(AW)) u_map (
        .size1(size1), .size2(size2), .buf1(b1), .buf2(b2), .pos(pos),
        .byte_addr(byte_addr), .cap(cap), .end_b1(end_b1), .end_cap(end_cap),
        .full(full)
    );

    rxd_status_fmt u_fmt (
        .len(pos), .ftype(ftype), .crc(crc), .phy(phy), .ovf(ovf),
        .word(stat_word)
    );

    assign ptr_load = (state == ST_IDLE) && run && !ptr_valid;
    assign ptr_adv  = (state == ST_WR_STAT) && mem_ack;

    rxd_ring_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .advance(ptr_adv),
        .wrap(eor), .base(ring_base), .ptr(ptr), .valid(ptr_valid)
    );

    assign lane      = byte_addr[1:0];
    assign take      = rx_valid && ((state == ST_RECV) ||
                                    ((state == ST_WAIT_SOF) && rx_sof));
    assign flush_now = (lane == 2'd3) || rx_eof || end_b1 || end_cap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (run) nxt = ST_RD_OWN;
            ST_RD_OWN:  if (mem_ack) nxt = mem_rdata[OWN_BIT] ? ST_RD_SIZE : ST_SUSPEND;
            ST_SUSPEND: begin
                if (!run)      nxt = ST_IDLE;
                else if (poll) nxt = ST_RD_OWN;
            end
            ST_RD_SIZE: if (mem_ack) nxt = ST_RD_BUF1;
            ST_RD_BUF1: if (mem_ack) nxt = ST_RD_BUF2;
            ST_RD_BUF2: if (mem_ack) nxt = ST_WAIT_SOF;
            ST_WAIT_SOF, ST_RECV: begin
                if (take) begin
                    if (full)           nxt = rx_eof ? ST_WR_STAT : ST_DISCARD;
                    else if (flush_now) nxt = ST_WR_DATA;
                    else                nxt = ST_RECV;
                end else if ((state == ST_WAIT_SOF) && !run) begin
                    nxt = ST_IDLE;
                end
            end
            ST_WR_DATA: if (mem_ack) nxt = done ? ST_WR_STAT : ST_RECV;
            ST_DISCARD: if (rx_valid && rx_eof) nxt = ST_WR_STAT;
            ST_WR_STAT: if (mem_ack) nxt = run ? ST_RD_OWN : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        mem_be    = '0;
        rx_ready  = 1'b0;
        unique case (state)
            ST_RD_OWN:  mem_req = 1'b1;
            ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = ptr + AW'(4);  end
            ST_RD_BUF1: begin mem_req = 1'b1; mem_addr = ptr + AW'(8);  end
            ST_RD_BUF2: begin mem_req = 1'b1; mem_addr = ptr + AW'(12); end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = waddr;
                mem_wdata = wbuf;
                mem_be    = wbe;
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_word;
                mem_be    = 4'hF;
            end
            ST_WAIT_SOF, ST_RECV, ST_DISCARD: rx_ready = 1'b1;
            default: ;
        endcase
    end

    // Descriptor fields and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size1 <= '0; size2 <= '0; eor <= 1'b0;
            b1 <= '0; b2 <= '0; pos <= '0;
            wbuf <= '0; wbe <= '0; waddr <= '0;
            done <= 1'b0; ovf <= 1'b0; ftype <= 1'b0; crc <= 1'b0; phy <= 1'b0;
        end else begin
            unique case (state)
                ST_RD_SIZE: if (mem_ack) begin
                    size1 <= mem_rdata[SZ1_LSB +: SZ_W];
                    size2 <= mem_rdata[SZ2_LSB +: SZ_W];
                    eor   <= mem_rdata[EOR_BIT];
                end
                ST_RD_BUF1: if (mem_ack) b1 <= mem_rdata[AW-1:0];
                ST_RD_BUF2: if (mem_ack) begin
                    b2 <= mem_rdata[AW-1:0];
                    pos <= '0; wbe <= '0; wbuf <= '0;
                    done <= 1'b0; ovf <= 1'b0; crc <= 1'b0; phy <= 1'b0;
                end
                ST_WAIT_SOF, ST_RECV: if (take) begin
                    if (state == ST_WAIT_SOF) ftype <= rx_ftype;
                    phy <= phy | rx_phy_err;
                    if (rx_eof) crc <= rx_crc_err;
                    if (full) begin
                        ovf <= 1'b1;
                    end else begin
                        wbuf[{lane, 3'b000} +: 8] <= rx_data;
                        wbe[lane]                 <= 1'b1;
                        waddr                     <= {byte_addr[AW-1:2], 2'b00};
                        pos                       <= pos + LEN_W'(1);
                        done                      <= rx_eof;
                    end
                end
                ST_WR_DATA: if (mem_ack) begin
                    wbe  <= '0;
                    wbuf <= '0;
                end
                ST_DISCARD: if (rx_valid) begin
                    phy <= phy | rx_phy_err;
                    if (rx_eof) crc <= rx_crc_err;
                end
                default: ;
            endcase
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_req && !rx_ready));

    p_no_take_suspended_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPEND) |-> (!rx_ready && !mem_req));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_DATA) |-> ((pos <= cap) && (mem_be != 4'h0)));

    p_wb_gives_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_STAT && mem_req) |->
            (!mem_wdata[OWN_BIT] && mem_wdata[FIRST_BIT] && mem_wdata[LAST_BIT]));

    p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_STAT && mem_req) |->
            (mem_wdata[SUM_BIT] == (mem_wdata[CRC_BIT] | mem_wdata[PHY_BIT] |
                                    mem_wdata[OVF_BIT])));
endmodule

// File: tb/rx_desc_wb_engine_bench.sv
`timescale 1ns/100ps
module rx_desc_wb_engine_bench;
    localparam int AW = 12;
    localparam int RB = 32'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          poll = 1'b0;
    logic [AW-1:0] ring_base = AW'(RB);
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [3:0]    mem_be;
    logic          rx_valid = 1'b0, rx_ready;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_sof = 1'b0, rx_eof = 1'b0, rx_ftype = 1'b0;
    logic          rx_crc_err = 1'b0, rx_phy_err = 1'b0;

    logic [31:0]   mem [0:1023];
    int            rd_cnt = 0;
    logic [AW-1:0] last_rd = '0;
    int            hold_bad = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    int            n_chk = 0;
    int            n_fail = 0;

    int s1 [3] = '{5, 8, 3};
    int s2 [3] = '{6, 0, 4};

    always #2.5 clk = ~clk;

    rx_desc_wb_engine #(.AW(AW)) u_rx_desc_wb_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_ftype(rx_ftype),
        .rx_crc_err(rx_crc_err), .rx_phy_err(rx_phy_err)
    );

    initial mem_ack = 1'b0;
    initial mem_rdata = '0;

    // Memory model: one-cycle acknowledge, byte-lane writes
    always @(posedge clk) begin
        if (pend && (!mem_req || mem_addr != pend_addr)) hold_bad <= hold_bad + 1;
        pend      <= mem_req && !mem_ack;
        pend_addr <= mem_addr;
        mem_ack   <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[AW-1:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[AW-1:2]];
                rd_cnt    <= rd_cnt + 1;
                last_rd   <= mem_addr;
            end
        end
    end

    function automatic int b1a(int d); return 32'h400 + 64*d + d; endfunction
    function automatic int b2a(int d); return 32'h600 + 64*d + 2*d; endfunction
    function automatic logic [7:0] pat(int k, int j); return 8'((k*37 + j*11 + 5) & 255); endfunction
    function automatic logic [7:0] rdb(int a); return mem[a/4][8*(a%4) +: 8]; endfunction
    task automatic wrb(int a, logic [7:0] v); mem[a/4][8*(a%4) +: 8] = v; endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] d, logic s, logic e, logic pe, logic ft, logic ce);
        rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
        rx_phy_err = pe; rx_ftype = ft; rx_crc_err = ce;
        forever begin
            @(negedge clk);
            if (rx_ready) break;
        end
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_phy_err = 1'b0; rx_crc_err = 1'b0;
    endtask

    task automatic run_frame(int k, int len, bit ft, bit ce, bit pe, int pre, bit halt);
        int d, da, cap, st, lr, got;
        bit ov;
        logic [31:0] exp;
        d  = k % 3;
        da = RB + 32*d;
        for (int j = 0; j < 16; j++) begin
            wrb(b1a(d) + j, 8'hEE);
            wrb(b2a(d) + j, 8'hEE);
        end
        @(negedge clk);
        mem[da/4] = 32'h8000_0000;
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        for (int j = 0; j < pre; j++) send_byte(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int j = 0; j < len; j++) begin
            if (halt && j == 2) run = 1'b0;
            send_byte(pat(k, j), j == 0, j == len - 1, pe && (j == len/2), ft, ce);
        end
        got = 0;
        for (int w = 0; w < 3000; w++) begin
            @(negedge clk);
            if (!mem[da/4][31]) begin got = 1; break; end
        end
        chk($sformatf("R6 frame %0d descriptor returned", k), 32'(got), 32'd1);
        cap = s1[d] + s2[d];
        st  = (len < cap) ? len : cap;
        ov  = (len > cap);
        lr  = ft ? ((st >= 4) ? st - 4 : 0) : st;
        exp = (32'(lr) << 16) | 32'h300 | (32'(ft) << 5) | (32'(ce) << 1) |
              (32'(pe) << 3) | (32'(ov) << 11);
        if (ce || pe || ov) exp = exp | 32'h8000;
        chk($sformatf("R5 R6 R7 frame %0d status", k), mem[da/4], exp);
        for (int j = 0; j <= s1[d]; j++)
            chk($sformatf("R4 R5 R9 frame %0d buf1 byte %0d", k, j), 32'(rdb(b1a(d) + j)),
                32'((j < s1[d] && j < st) ? pat(k, j) : 8'hEE));
        for (int j = 0; j <= s2[d]; j++)
            chk($sformatf("R4 R5 frame %0d buf2 byte %0d", k, j), 32'(rdb(b2a(d) + j)),
                32'((j < s2[d] && s1[d] + j < st) ? pat(k, s1[d] + j) : 8'hEE));
        if (!halt) begin
            cycles(15);
            chk($sformatf("R8 frame %0d next fetch", k), 32'(last_rd), RB + 32*((d + 1) % 3));
            chk($sformatf("R2 frame %0d suspended not ready", k), 32'(rx_ready), 32'd0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rc;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int d = 0; d < 3; d++) begin
            mem[(RB + 32*d)/4 + 1] = 32'(s1[d]) | (32'(s2[d]) << 16) | ((d == 2) ? 32'h8000 : 32'h0);
            mem[(RB + 32*d)/4 + 2] = 32'(b1a(d));
            mem[(RB + 32*d)/4 + 3] = 32'(b2a(d));
        end
        cycles(5);
        rst_n = 1'b1;
        cycles(10);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
        chk("R1 rx_ready after reset", 32'(rx_ready), 32'd0);
        chk("R1 no reads while stopped", 32'(rd_cnt), 32'd0);

        run = 1'b1;
        cycles(20);
        chk("R2 one read of software-owned desc", 32'(rd_cnt), 32'd1);
        chk("R2 read at ring base", 32'(last_rd), RB);
        chk("R2 suspended not ready", 32'(rx_ready), 32'd0);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        cycles(20);
        chk("R3 poll re-reads once", 32'(rd_cnt), 32'd2);
        chk("R3 poll same pointer", 32'(last_rd), RB);

        for (int k = 0; k < 26; k++)
            run_frame(k, (k % 13) + 1,
                      (k >= 13) ? (k % 2 == 1) : (k % 3 == 0),
                      (k % 4 == 1), (k % 5 == 2), k % 2, 1'b0);

        run_frame(26, 6, 1'b0, 1'b0, 1'b0, 0, 1'b1);
        rc = rd_cnt;
        cycles(30);
        chk("R10 no access after halt", 32'(rd_cnt), 32'(rc));
        ring_base = AW'(32'h080);
        run = 1'b1;
        cycles(15);
        chk("R10 resume reads once", 32'(rd_cnt), 32'(rc + 1));
        chk("R10 R8 resume at held wrapped pointer", 32'(last_rd), RB);
        chk("R11 request held until ack", 32'(hold_bad), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule